// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each line owns one bit in every bit-mapped register: bit n belongs to source n. A parameter mask chooses how each source is captured. A source can be captured on a rising edge or whenever its input is high. A captured request stays latched in the status register until software clears it. This happens whether or not the source is enabled.

Software reaches the block through a simple word-indexed bus with eight registers. A write takes effect at the clock edge, and a read returns data in the same cycle. Software can write the enable mask directly, or change it through a set-only port and a clear-only port that leave unmarked bits alone. Requests are cleared by writing ones to an acknowledge port. A vector register names the lowest-numbered source that is both captured and enabled, which is the source to service. The output is raised only when a request is pending and both bits of the two-bit master control register are set.

An edge source is acknowledged before it is serviced. A level source is acknowledged after service, and it is captured again at once if its line is still high.

Top module: `vic_top`

## Requirements
- R1: After reset, status, enable and master control are all zero, the pending register reads 0, the vector register reads 0xFFFFFFFF and `irq_o` is low.
- R2: Register index decode is: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. Indices 3, 4 and 5 are write-only and always read 0. The master control register reads its value in bits 1:0, with zero above.
- R3: When `EDGE_MASK[n]` is 1, source n is edge-captured: its status bit is set at the clock edge where `src_i[n]` is 1 and was 0 at the previous edge. When `EDGE_MASK[n]` is 0, source n is level-captured: its status bit is set at every clock edge where `src_i[n]` is 1. Capture happens regardless of the enable bit.
- R4: A write to index 4 sets the enable bits marked 1 in the write data and leaves every other enable bit unchanged.
- R5: A write to index 5 clears the enable bits marked 1 in the write data and leaves every other enable bit unchanged.
- R6: A write to index 2 replaces the whole enable mask. Writing 0 disables every source at once.
- R7: A write to index 3 clears the status bits marked 1 in the write data. Writing all ones clears every captured request. A capture event on the same bit in the same cycle wins, so a level source whose line is still high is set again.
- R8: The pending register (index 1) equals status AND enable.
- R9: `irq_o` is high exactly when the pending register is non-zero and the master control register holds 2'b11. Either master bit on its own keeps the output low.
- R10: The vector register (index 6) returns the index of the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R11: Writes to indices 0, 1 and 6 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request lines, synchronous to clk_i |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the indexed register, same cycle |
| irq_o | output | 1 | Interrupt output to the processor |

## Verification
The bench acknowledges a level source while its line is still high. A design that lets the acknowledge win would lose the request, and the status read after the acknowledge would show a zero. It holds an edge source high across an acknowledge. A design that treats that source as level-captured would capture it again, so the stale request would stay latched. It programs the master control register with each bit alone, which catches an output gated by OR instead of AND. It also fills the pending set with several sources, to expose a vector that picks the highest index or fails to report all ones when nothing is pending. Writes to the read-only indices and partial set and clear masks are checked against a behavioural model every cycle. A random phase then mixes capture, enable and acknowledge traffic.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int IDX_W    = 3;
    localparam int MASTER_W = 2;

    typedef enum logic [IDX_W-1:0] {
        RI_STATUS = 3'd0,
        RI_PEND   = 3'd1,
        RI_ENAB   = 3'd2,
        RI_ACK    = 3'd3,
        RI_SETEN  = 3'd4,
        RI_CLREN  = 3'd5,
        RI_VEC    = 3'd6,
        RI_MASTER = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/vic_event_detect.sv
module vic_event_detect #(
    parameter int               N         = 32,
    parameter logic [N-1:0]     EDGE_MASK = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        if (EDGE_MASK[g]) begin : g_edge
            assign evt_o[g] = src_i[g] & ~prev_q[g];
        end else begin : g_level
            assign evt_o[g] = src_i[g];
        end
    end
endmodule

// File: rtl/vic_lowest_pick.sv
module vic_lowest_pick #(
    parameter int N     = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int                 NUM_SRC   = 32,
    parameter int                 DATA_W    = 32,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_SRC-1:0]        src_i,
    input  logic                      bus_sel_i,
    input  logic                      bus_wr_i,
    input  logic [vic_pkg::IDX_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    output logic [DATA_W-1:0]         bus_rdata_o,
    output logic                      irq_o
);
    import vic_pkg::*;

    localparam int VEC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0]  status;
        logic [NUM_SRC-1:0]  enable;
        logic [MASTER_W-1:0] master;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] ack_mask;
    logic               vec_found;
    logic [VEC_W-1:0]   vec_idx;
    logic               wr_en;

    // Signals exposed to the bound checker
    logic [NUM_SRC-1:0]  status_q;
    logic [NUM_SRC-1:0]  enable_q;
    logic [MASTER_W-1:0] master_q;

    vic_event_detect #(
        .N         (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_evt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .evt_o  (evt)
    );

    vic_lowest_pick #(
        .N (NUM_SRC)
    ) u_pick (
        .req_i   (pending),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    assign wr_en    = bus_sel_i & bus_wr_i;
    assign wmask    = bus_wdata_i[NUM_SRC-1:0];
    assign pending  = st_q.status & st_q.enable;
    assign status_q = st_q.status;
    assign enable_q = st_q.enable;
    assign master_q = st_q.master;

    // Next-state logic
    always_comb begin
        st_d     = st_q;
        ack_mask = '0;
        if (wr_en) begin
            case (reg_idx_e'(bus_addr_i))
                RI_ENAB:   st_d.enable = wmask;
                RI_SETEN:  st_d.enable = st_q.enable | wmask;
                RI_CLREN:  st_d.enable = st_q.enable & ~wmask;
                RI_ACK:    ack_mask    = wmask;
                RI_MASTER: st_d.master = bus_wdata_i[MASTER_W-1:0];
                default:   ;
            endcase
        end
        // capture event overrides a same-cycle acknowledge
        st_d.status = (st_q.status & ~ack_mask) | evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Read path, same cycle
    always_comb begin
        bus_rdata_o = '0;
        case (reg_idx_e'(bus_addr_i))
            RI_STATUS: bus_rdata_o[NUM_SRC-1:0]  = st_q.status;
            RI_PEND:   bus_rdata_o[NUM_SRC-1:0]  = pending;
            RI_ENAB:   bus_rdata_o[NUM_SRC-1:0]  = st_q.enable;
            RI_VEC:    bus_rdata_o               = vec_found ? DATA_W'(vec_idx) : '1;
            RI_MASTER: bus_rdata_o[MASTER_W-1:0] = st_q.master;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_o = (&st_q.master) & (|pending);
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int N      = 32,
    parameter int DATA_W = 32,
    localparam int VEC_W = (N > 1) ? $clog2(N) : 1
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      bus_sel_i,
    input logic                      bus_wr_i,
    input logic [vic_pkg::IDX_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0]         bus_wdata_i,
    input logic                      irq_o,
    input logic [N-1:0]              status_q,
    input logic [N-1:0]              enable_q,
    input logic [1:0]                master_q,
    input logic [N-1:0]              evt,
    input logic                      vec_found,
    input logic [VEC_W-1:0]          vec_idx
);
    logic [N-1:0] wd;
    logic [N-1:0] pend;
    logic [N-1:0] below;
    logic         wr_set, wr_clr, wr_ack, wr_ro;

    assign wd     = bus_wdata_i[N-1:0];
    assign pend   = status_q & enable_q;
    assign below  = (N'(1) << vec_idx) - N'(1);
    assign wr_set = bus_sel_i && bus_wr_i && bus_addr_i == 3'd4;
    assign wr_clr = bus_sel_i && bus_wr_i && bus_addr_i == 3'd5;
    assign wr_ack = bus_sel_i && bus_wr_i && bus_addr_i == 3'd3;
    assign wr_ro  = bus_sel_i && bus_wr_i &&
                    (bus_addr_i == 3'd0 || bus_addr_i == 3'd1 || bus_addr_i == 3'd6);

    a_r3_event_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_q & $past(evt)) == $past(evt)));

    a_r4_set_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_set |=> (((enable_q & $past(wd)) == $past(wd)) &&
                    ((enable_q & ~$past(wd)) == ($past(enable_q) & ~$past(wd)))));

    a_r5_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_clr |=> (((enable_q & $past(wd)) == '0) &&
                    ((enable_q & ~$past(wd)) == ($past(enable_q) & ~$past(wd)))));

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ack |=> ((status_q & $past(wd) & ~$past(evt)) == '0));

    a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (master_q == 2'b11 && pend != '0));

    a_r10_vec_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_found |-> (pend[vec_idx] && (pend & below) == '0));

    a_r10_vec_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_found |-> pend == '0);

    a_r11_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ro |=> (enable_q == $past(enable_q) && master_q == $past(master_q)));
endmodule

bind vic_top vic_checker #(
    .N      (NUM_SRC),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .master_q    (master_q),
    .evt         (evt),
    .vec_found   (vec_found),
    .vec_idx     (vec_idx)
);

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
    localparam logic [31:0] EDGES = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vic_top #(.NUM_SRC(32), .DATA_W(32), .EDGE_MASK(EDGES)) dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // Behavioural reference model
    logic [31:0] m_st, m_en, m_prev;
    logic [1:0]  m_ms;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_prev = '0; m_ms = '0;
        end else begin
            logic [31:0] ev;
            logic [31:0] ack;
            ack = '0;
            for (int i = 0; i < 32; i++)
                ev[i] = EDGES[i] ? (src[i] && !m_prev[i]) : src[i];
            if (sel && wr) begin
                case (addr)
                    3'd2: m_en = wdata;
                    3'd3: ack = wdata;
                    3'd4: m_en = m_en | wdata;
                    3'd5: m_en = m_en & ~wdata;
                    3'd7: m_ms = wdata[1:0];
                    default: ;
                endcase
            end
            m_st = (m_st & ~ack) | ev;
            m_prev = src;
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] p;
        logic [31:0] v;
        p = m_st & m_en;
        v = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) if (p[i]) v = i;
        case (a)
            3'd0: return m_st;
            3'd1: return p;
            3'd2: return m_en;
            3'd6: return v;
            3'd7: return {30'd0, m_ms};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R3";
            3'd1: return "R8";
            3'd2: return "R6";
            3'd6: return "R10";
            3'd7: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [31:0] s, input logic sl, input logic w,
                        input logic [2:0] a, input logic [31:0] wd, input string tag = "");
        @(negedge clk);
        src = s; sel = sl; wr = w; addr = a; wdata = wd;
        #1;
        chk("R9", {31'd0, irq}, {31'd0, (&m_ms) && ((m_st & m_en) != 0)});
        if (sl && !w) chk((tag == "") ? addr_tag(a) : tag, rdata, exp_read(a));
    endtask

    task automatic rd(input logic [31:0] s, input logic [2:0] a, input string tag = "");
        step(s, 1'b1, 1'b0, a, 32'd0, tag);
    endtask

    task automatic wrt(input logic [31:0] s, input logic [2:0] a, input logic [31:0] d);
        step(s, 1'b1, 1'b1, a, d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd(0, 3'd0, "R1"); rd(0, 3'd1, "R1"); rd(0, 3'd2, "R1");
        rd(0, 3'd6, "R1"); rd(0, 3'd7, "R1");
        chk("R1", {31'd0, irq}, 32'd0);
        // R2 write-only indices read zero
        wrt(0, 3'd2, 32'h00FF_00FF);
        rd(0, 3'd3, "R2"); rd(0, 3'd4, "R2"); rd(0, 3'd5, "R2");
        wrt(0, 3'd2, 32'h0);
        // R3 edge capture on source 3, held high, while disabled
        wrt(32'h8, 3'd7, 32'h0);
        rd(32'h8, 3'd0, "R3");
        rd(32'h8, 3'd1, "R8");
        // R7 edge source acked while still high stays clear
        wrt(32'h8, 3'd3, 32'h8);
        rd(32'h8, 3'd0, "R7");
        rd(32'h0, 3'd0, "R7");
        // R3/R7 level source 20, ack while high is re-captured
        rd(32'h0010_0000, 3'd0, "R3");
        wrt(32'h0010_0000, 3'd3, 32'hFFFF_FFFF);
        rd(32'h0010_0000, 3'd0, "R7");
        wrt(32'h0, 3'd3, 32'hFFFF_FFFF);
        rd(32'h0, 3'd0, "R7");
        // R4 / R5 / R6 enable ports
        wrt(0, 3'd4, 32'h0010_0008);
        rd(0, 3'd2, "R4");
        wrt(0, 3'd4, 32'h8000_0001);
        rd(0, 3'd2, "R4");
        wrt(0, 3'd5, 32'h0000_0009);
        rd(0, 3'd2, "R5");
        wrt(0, 3'd2, 32'h0);
        rd(0, 3'd2, "R6");
        wrt(0, 3'd2, 32'hFFFF_FFFF);
        // R9 master gating with a pending request
        rd(32'h0004_0020, 3'd0, "R3");
        wrt(32'h0004_0020, 3'd7, 32'h1);
        rd(32'h0004_0020, 3'd7, "R9");
        wrt(32'h0004_0020, 3'd7, 32'h2);
        rd(32'h0004_0020, 3'd7, "R9");
        wrt(32'h0004_0020, 3'd7, 32'hFFFF_FFFF);
        rd(32'h0004_0020, 3'd7, "R9");
        chk("R9", {31'd0, irq}, 32'd1);
        // R10 vector: lowest of 5 and 18, then 18, then none
        rd(32'h0004_0000, 3'd6, "R10");
        wrt(32'h0004_0000, 3'd3, 32'h20);
        rd(32'h0, 3'd6, "R10");
        wrt(32'h0, 3'd3, 32'hFFFF_FFFF);
        rd(32'h0, 3'd6, "R10");
        chk("R10", rdata, 32'hFFFF_FFFF);
        // R11 writes to read-only indices
        wrt(32'h4, 3'd0, 32'hFFFF_FFFF);
        wrt(32'h4, 3'd1, 32'h0);
        wrt(32'h4, 3'd6, 32'h0);
        rd(32'h4, 3'd2, "R11");
        rd(32'h4, 3'd0, "R11");
        rd(32'h4, 3'd7, "R11");
        // R8 pending under a partial enable
        wrt(32'h4, 3'd2, 32'h0000_0005);
        rd(32'h5, 3'd1, "R8");
        // random mixed traffic
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] s;
            logic [2:0]  a;
            logic [31:0] d;
            s = $urandom & $urandom;
            a = 3'($urandom);
            d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : ($urandom | $urandom);
            step(s, 1'($urandom), 1'($urandom), a, d);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule